// File: doc/BRIEF.md
# Orthogonal Systolic Matrix Multiplier

This block multiplies two dense square matrices of fixed odd order N on an N×N grid of multiply-add cells that keep no running total. Partial sums travel straight down the columns, one row per cycle. Row operands of A sweep left to right and column operands of B sweep right to left through the same grid rows. Grid row k only ever carries operands with inner index k, so a partial sum passing down a column picks up exactly one product per inner index. Each sum carries its (i, j) tag with it, and is written into the result register file as it leaves the bottom row.

A one-cycle `start` while idle copies both input matrices into internal register files and launches a fixed, skewed injection schedule. Column q receives the sums c(i, (i+q) mod N), with c(i, j) entering at relative time i + j. A-operands enter at the left edge and B-operands at the right edge, early enough to meet the sums at the cells where they are needed. Because N is odd, no two sums share a column slot and no two operands share an edge slot. Operand injection begins N−1 cycles before the first sum enters, and the last sum leaves 3N−2 cycles after the first one enters.

Top module: `sysmm_top`

## Requirements
- R1: After a run, every result entry (i, j) equals the exact unsigned sum over k of A(i,k)·B(k,j), with no overflow even when every operand is all-ones. Entries are AW = 2·DW + clog2(N) bits wide.
- R2: After reset, `busy` and `done` are low and every result entry reads zero.
- R3: The input matrices are sampled only on the edge that accepts `start`. Changing `a_mat` or `b_mat` during a run does not alter that run's results.
- R4: A `start` asserted while `busy` is high is ignored. The run in progress keeps its timing and results, and no second run follows.
- R5: `done` is a single-cycle pulse. It appears in the cycle 4N−3 clock edges after the accepting edge, which is 3N−2 cycles after the first partial sum enters the grid. `busy` is high for the 4N−3 cycles before that pulse and low during it.
- R6: Result entry (i, j) is updated on the output 2N−1+i+j edges after the accepting edge. Until then it keeps its previous value.
- R7: A cell that holds a live partial sum in a cycle always sees a valid A-operand and a valid B-operand in that same cycle. Partial sums enter the top row as zero.
- R8: Between runs the result file holds its contents unchanged.
- R9: A `start` asserted in the cycle where `done` is high is accepted, and the new run follows the same timing.
- R10: Operand and sum packing: entry (x, y) of `a_mat`, `b_mat` and `c_mat` sits at bit offset (x·N + y) times the element width.

Ports, for the defaults N = 3, DW = 8 (AW = 18):

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a run; honoured only while idle |
| a_mat | input | N·N·DW | Left matrix, row-major |
| b_mat | input | N·N·DW | Right matrix, row-major |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| c_mat | output | N·N·AW | Result register file, row-major |

## Verification
The hardest situations to reach from the ports involve a run that is disturbed while in flight. In one case, the input matrices change and a second `start` arrives a cycle after launch. The bench then checks, cycle by cycle, that every result entry still lands at its scheduled edge with the originally sampled values. In the other case, `start` is raised in the exact cycle of `done`, so that a fresh run overlaps the draining operand streams of the previous one. Each entry is tracked every cycle against its reveal time i + j, so a slip of one cycle in the skewed feed, or a sum that lands in the wrong column, shows up as a mismatch.

// File: rtl/sysmm_pkg.sv
package sysmm_pkg;

    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} mm_state_e;

    function automatic int acc_bits(int n, int dw);
        return 2 * dw + $clog2(n);
    endfunction

    function automatic int tag_bits(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Row index i of the partial sum entering the top of column q at time t, else -1.
    function automatic int top_entry(int n, int q, int t);
        int r;
        r = -1;
        for (int i = 0; i < n; i++)
            if (i + ((i + q) % n) == t) r = i;
        return r;
    endfunction

    // Row index i of the A operand (inner index = grid row) entering on the left, else -1.
    function automatic int left_entry(int n, int row, int t);
        int r;
        r = -1;
        for (int i = 0; i < n; i++)
            if ((2 * i + row == t) || (i > 0 && 2 * i - n + row == t)) r = i;
        return r;
    endfunction

    // Column index j of the B operand (inner index = grid row) entering on the right, else -1.
    function automatic int right_entry(int n, int row, int t);
        int r;
        r = -1;
        for (int j = 0; j < n; j++)
            if ((2 * j + row - n + 1 == t) || (j < n - 1 && 2 * j + row + 1 == t)) r = j;
        return r;
    endfunction

endpackage

// File: rtl/sysmm_cell.sv
module sysmm_cell #(
    parameter int DW = 8,
    parameter int AW = 18
) (
    input  logic          a_v,
    input  logic [DW-1:0] a_d,
    input  logic          b_v,
    input  logic [DW-1:0] b_d,
    input  logic          c_v,
    input  logic [AW-1:0] c_d,
    output logic [AW-1:0] c_o
);
    logic [AW-1:0] prod;

    always_comb begin
        prod = AW'(a_d) * AW'(b_d);
        c_o  = (a_v && b_v && c_v) ? c_d + prod : c_d;
    end
endmodule

// File: rtl/sysmm_ctrl.sv
module sysmm_ctrl
    import sysmm_pkg::*;
#(
    parameter int N  = 3,
    parameter int TW = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    output logic                 run,
    output logic                 load,
    output logic                 done,
    output logic signed [TW-1:0] t
);
    localparam int LAST = 4 * N - 4;

    mm_state_e     st;
    logic [TW-1:0] u;

    assign run  = (st == ST_RUN);
    assign load = start && (st == ST_IDLE);
    assign t    = $signed(u) - $signed(TW'(N - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            u    <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    st <= ST_RUN;
                    u  <= '0;
                end
                default: if (u == TW'(LAST)) begin
                    st   <= ST_IDLE;
                    done <= 1'b1;
                end else begin
                    u <= u + 1'b1;
                end
            endcase
        end
    end

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    p_run_ends_r5:   assert property (@(posedge clk) disable iff (rst) $fell(run) |-> done);
    p_busy_start_r4: assert property (@(posedge clk) disable iff (rst) (run && start) |=> (run || done));
endmodule

// File: rtl/sysmm_feed.sv
module sysmm_feed
    import sysmm_pkg::*;
#(
    parameter int N  = 3,
    parameter int DW = 8,
    parameter int IW = 2,
    parameter int TW = 5
) (
    input  logic                           run,
    input  logic signed [TW-1:0]           t,
    input  logic [N-1:0][N-1:0][DW-1:0]    a_rf,
    input  logic [N-1:0][N-1:0][DW-1:0]    b_rf,
    output logic                           ea_v [N],
    output logic [DW-1:0]                  ea_d [N],
    output logic                           eb_v [N],
    output logic [DW-1:0]                  eb_d [N],
    output logic                           ec_v [N],
    output logic [IW-1:0]                  ec_i [N],
    output logic [IW-1:0]                  ec_j [N]
);
    for (genvar g = 0; g < N; g++) begin : g_edge
        int            ia, jb, ic;
        logic [IW-1:0] ax, bx, cx;
        always_comb begin
            ia = left_entry(N, g, int'(t));
            jb = right_entry(N, g, int'(t));
            ic = top_entry(N, g, int'(t));
            ax = IW'(ia);
            bx = IW'(jb);
            cx = IW'(ic);
            ea_v[g] = run && (ia >= 0);
            ea_d[g] = (ia >= 0) ? a_rf[ax][g] : '0;
            eb_v[g] = run && (jb >= 0);
            eb_d[g] = (jb >= 0) ? b_rf[g][bx] : '0;
            ec_v[g] = run && (ic >= 0);
            ec_i[g] = cx;
            ec_j[g] = IW'((ic + g) % N);
        end
    end
endmodule

// File: rtl/sysmm_array.sv
module sysmm_array #(
    parameter int N  = 3,
    parameter int DW = 8,
    parameter int AW = 18,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ea_v [N],
    input  logic [DW-1:0] ea_d [N],
    input  logic          eb_v [N],
    input  logic [DW-1:0] eb_d [N],
    input  logic          ec_v [N],
    input  logic [IW-1:0] ec_i [N],
    input  logic [IW-1:0] ec_j [N],
    output logic          bot_v [N],
    output logic [AW-1:0] bot_c [N],
    output logic [IW-1:0] bot_i [N],
    output logic [IW-1:0] bot_j [N]
);
    // Horizontal hops: a moves right, b moves left; vertical hops carry sums.
    logic          av_q [N][N-1];
    logic [DW-1:0] ad_q [N][N-1];
    logic          bv_q [N][N-1];
    logic [DW-1:0] bd_q [N][N-1];
    logic          cv_q [N-1][N];
    logic [AW-1:0] cd_q [N-1][N];
    logic [IW-1:0] ci_q [N-1][N];
    logic [IW-1:0] cj_q [N-1][N];

    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar q = 0; q < N; q++) begin : g_col
            logic          ain_v, bin_v, cin_v;
            logic [DW-1:0] ain_d, bin_d;
            logic [AW-1:0] cin_d, cout_d;
            logic [IW-1:0] cin_i, cin_j;

            if (q == 0) begin : g_al
                assign ain_v = ea_v[r];
                assign ain_d = ea_d[r];
            end else begin : g_ai
                assign ain_v = av_q[r][q-1];
                assign ain_d = ad_q[r][q-1];
            end

            if (q == N - 1) begin : g_br
                assign bin_v = eb_v[r];
                assign bin_d = eb_d[r];
            end else begin : g_bi
                assign bin_v = bv_q[r][q];
                assign bin_d = bd_q[r][q];
            end

            if (r == 0) begin : g_ct
                assign cin_v = ec_v[q];
                assign cin_d = '0;
                assign cin_i = ec_i[q];
                assign cin_j = ec_j[q];
            end else begin : g_ci
                assign cin_v = cv_q[r-1][q];
                assign cin_d = cd_q[r-1][q];
                assign cin_i = ci_q[r-1][q];
                assign cin_j = cj_q[r-1][q];
            end

            sysmm_cell #(.DW(DW), .AW(AW)) u_cell (
                .a_v(ain_v), .a_d(ain_d), .b_v(bin_v), .b_d(bin_d),
                .c_v(cin_v), .c_d(cin_d), .c_o(cout_d)
            );

            if (q < N - 1) begin : g_ah
                always_ff @(posedge clk) begin
                    if (rst) av_q[r][q] <= 1'b0;
                    else     av_q[r][q] <= ain_v;
                    ad_q[r][q] <= ain_d;
                end
            end

            if (q > 0) begin : g_bh
                always_ff @(posedge clk) begin
                    if (rst) bv_q[r][q-1] <= 1'b0;
                    else     bv_q[r][q-1] <= bin_v;
                    bd_q[r][q-1] <= bin_d;
                end
            end

            if (r < N - 1) begin : g_ch
                always_ff @(posedge clk) begin
                    if (rst) cv_q[r][q] <= 1'b0;
                    else     cv_q[r][q] <= cin_v;
                    cd_q[r][q] <= cout_d;
                    ci_q[r][q] <= cin_i;
                    cj_q[r][q] <= cin_j;
                end
            end else begin : g_out
                assign bot_v[q] = cin_v;
                assign bot_c[q] = cout_d;
                assign bot_i[q] = cin_i;
                assign bot_j[q] = cin_j;
            end

            p_pair_ready_r7: assert property (@(posedge clk) disable iff (rst)
                cin_v |-> (ain_v && bin_v));
            p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
                cin_v |-> (cout_d >= cin_d));
        end
    end
endmodule

// File: rtl/sysmm_top.sv
module sysmm_top
    import sysmm_pkg::*;
#(
    parameter int N  = 3,
    parameter int DW = 8
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic                                     start,
    input  logic [N*N*DW-1:0]                        a_mat,
    input  logic [N*N*DW-1:0]                        b_mat,
    output logic                                     busy,
    output logic                                     done,
    output logic [N*N*acc_bits(N, DW)-1:0]           c_mat
);
    localparam int AW = acc_bits(N, DW);
    localparam int IW = tag_bits(N);
    localparam int TW = $clog2(4 * N) + 1;

    logic                        run, load;
    logic signed [TW-1:0]        t;
    logic [N-1:0][N-1:0][DW-1:0] a_rf, b_rf;
    logic [N-1:0][N-1:0][AW-1:0] c_rf;

    logic          ea_v [N];
    logic [DW-1:0] ea_d [N];
    logic          eb_v [N];
    logic [DW-1:0] eb_d [N];
    logic          ec_v [N];
    logic [IW-1:0] ec_i [N];
    logic [IW-1:0] ec_j [N];
    logic          bot_v [N];
    logic [AW-1:0] bot_c [N];
    logic [IW-1:0] bot_i [N];
    logic [IW-1:0] bot_j [N];

    sysmm_ctrl #(.N(N), .TW(TW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .run(run), .load(load), .done(done), .t(t)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_rf <= '0;
            b_rf <= '0;
        end else if (load) begin
            a_rf <= a_mat;
            b_rf <= b_mat;
        end
    end

    sysmm_feed #(.N(N), .DW(DW), .IW(IW), .TW(TW)) u_feed (
        .run(run), .t(t), .a_rf(a_rf), .b_rf(b_rf),
        .ea_v(ea_v), .ea_d(ea_d), .eb_v(eb_v), .eb_d(eb_d),
        .ec_v(ec_v), .ec_i(ec_i), .ec_j(ec_j)
    );

    sysmm_array #(.N(N), .DW(DW), .AW(AW), .IW(IW)) u_array (
        .clk(clk), .rst(rst),
        .ea_v(ea_v), .ea_d(ea_d), .eb_v(eb_v), .eb_d(eb_d),
        .ec_v(ec_v), .ec_i(ec_i), .ec_j(ec_j),
        .bot_v(bot_v), .bot_c(bot_c), .bot_i(bot_i), .bot_j(bot_j)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            c_rf <= '0;
        end else begin
            for (int q = 0; q < N; q++)
                if (bot_v[q]) c_rf[bot_i[q]][bot_j[q]] <= bot_c[q];
        end
    end

    assign c_mat = c_rf;
    assign busy  = run;

    p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(c_mat));
    p_load_idle_r3: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(a_rf) && $stable(b_rf)));
endmodule

// File: tb/tb_sysmm_top.sv
`timescale 1ns/1ps
module tb_sysmm_top;
    localparam int N  = 3;
    localparam int DW = 8;
    localparam int AW = 2 * DW + $clog2(N);

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 start = 1'b0;
    logic [N*N*DW-1:0]    a_mat = '0;
    logic [N*N*DW-1:0]    b_mat = '0;
    logic                 busy, done;
    logic [N*N*AW-1:0]    c_mat;

    int errs = 0;
    int checks = 0;
    bit finished = 0;

    longint am [N][N];
    longint bm [N][N];
    longint ref_c  [N][N];
    longint prev_c [N][N];

    always #4 clk = ~clk;

    sysmm_top #(.N(N), .DW(DW)) dut (
        .clk(clk), .rst(rst), .start(start), .a_mat(a_mat), .b_mat(b_mat),
        .busy(busy), .done(done), .c_mat(c_mat)
    );

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic longint entry(int i, int j);
        return longint'(c_mat[(i*N+j)*AW +: AW]);
    endfunction

    // R10: element (x,y) at offset (x*N+y)*width
    task automatic drive_mats();
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++) begin
                a_mat[(i*N+k)*DW +: DW] = DW'(am[i][k]);
                b_mat[(i*N+k)*DW +: DW] = DW'(bm[i][k]);
            end
    endtask

    task automatic make_case(int mode);
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++) begin
                case (mode)
                    1: begin am[i][k] = 255; bm[i][k] = 255; end
                    2: begin am[i][k] = (i == k) ? 1 : 0; bm[i][k] = $urandom_range(0, 255); end
                    3: begin am[i][k] = 0; bm[i][k] = $urandom_range(0, 255); end
                    default: begin am[i][k] = $urandom_range(0, 255); bm[i][k] = $urandom_range(0, 255); end
                endcase
            end
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                ref_c[i][j] = 0;
                for (int k = 0; k < N; k++) ref_c[i][j] += am[i][k] * bm[k][j];
            end
    endtask

    // Called at a negedge. Launches a run and checks it every cycle.
    task automatic run_case(int mode, bit disturb, bit chain);
        int last;
        last = chain ? 4*N-3 : 4*N-1;
        make_case(mode);
        drive_mats();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int cnt = 0; cnt <= last; cnt++) begin
            // R5: done pulse timing and busy window
            chk(done == (cnt == 4*N-3), "R5 done", longint'(done), longint'(cnt == 4*N-3));
            chk(busy == (cnt <= 4*N-4), "R5 busy", longint'(busy), longint'(cnt <= 4*N-4));
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++) begin
                    if (cnt >= 2*N-1+i+j)
                        chk(entry(i, j) == ref_c[i][j], "R1 product", entry(i, j), ref_c[i][j]);
                    else
                        chk(entry(i, j) == prev_c[i][j], "R6 reveal", entry(i, j), prev_c[i][j]);
                end
            if (disturb && cnt == 1) begin
                // R3: new inputs mid-run; R4: start while busy
                a_mat = ~a_mat;
                b_mat = {N*N{8'h5a}};
                start = 1'b1;
            end
            if (disturb && cnt == 2) start = 1'b0;
            if (!(chain && cnt == last)) @(negedge clk);
        end
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) prev_c[i][j] = ref_c[i][j];
    endtask

    initial begin
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) prev_c[i][j] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2: reset state
        chk(busy == 1'b0, "R2 busy", longint'(busy), 0);
        chk(done == 1'b0, "R2 done", longint'(done), 0);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                chk(entry(i, j) == 0, "R2 result", entry(i, j), 0);

        run_case(0, 1'b1, 1'b0);   // R3, R4 disturbed run
        repeat (3) @(negedge clk);
        // R8: results held while idle
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                chk(entry(i, j) == prev_c[i][j], "R8 hold", entry(i, j), prev_c[i][j]);
        run_case(1, 1'b0, 1'b0);   // R1 all-ones operands
        run_case(2, 1'b0, 1'b1);   // identity, ends in the done cycle
        run_case(0, 1'b0, 1'b1);   // R9 start in done cycle
        run_case(3, 1'b0, 1'b0);   // R9 chained, zero matrix; R7 implied by exact sums
        for (int s = 0; s < 4; s++) run_case(0, 1'b0, 1'b0);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            checks++;
            errs++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule